// File: doc/BRIEF.md
# PCI Configuration Header Target

This block is the configuration-space register file for a single function of a multifunction PCI device. A bus front end, which is outside this block, decodes the configuration transaction. It presents an address phase and then one or more data phases. The address phase carries the device-select line, a configuration-command flag, the read/write direction and address bits [10:0]. Each data phase carries 32-bit write data and four active-low byte enables. The block decides whether the cycle belongs to it and selects a DWORD of the 64-byte predefined header. It then merges writes lane by lane into the writable fields, or returns the addressed DWORD one cycle after a read phase.

The identity fields are fixed by parameters: vendor, device, revision, class, subsystem, header type, interrupt pin and grant/latency values. The writable state is small: the command bits allowed by a mask, the latency timer, the interrupt line, the upper bits of one memory base address register, and five error flags in the status word. An external pulse sets an error flag, and software clears it by writing a one. Several data phases in one transaction walk through consecutive DWORDs, so a burst can read or write the header in a single pass.

Top module: `pci_cfg_header`

## Requirements
- R1: A transaction is claimed (`claimed` high from the cycle after the address phase) only when `idsel`=1, `cfgCmd`=1, `adAddr[1:0]`=00 and the function number `adAddr[10:8]`=000. Otherwise `claimed` stays low, data phases write nothing and `rdValid` stays low.
- R2: The first data phase addresses DWORD index `adAddr[7:2]` (byte address {index,00}). Index 0 is {device,vendor}, 1 is {status,command}, 2 is {class,revision}, 3 is {BIST,header type,latency timer,cache line}, 4 is the memory base register, 11 is {subsystem,subsystem vendor} and 15 is {max latency,min grant,interrupt pin,interrupt line}.
- R3: A data-phase write changes only the lanes whose `byteEnN` bit is 0, where bit n covers data bits [8n+7:8n]. Examples are the latency timer in lane 1 of index 3 and the interrupt line in lane 0 of index 15.
- R4: The identity fields, header type, interrupt pin, grant/latency values and the fixed status bits (default 16'h0200) are read-only, and writes to them have no effect. The command register keeps only the bits set in `CMD_WMASK` (default 16'h0146).
- R5: Every other field reads as zero and drops writes. This covers cache line size, BIST, the CardBus pointer, the expansion ROM base, indices 5–10, 12–14 and every index from 16 to 63.
- R6: Each further data phase of a claimed transaction targets the next DWORD index, for reads and writes alike. `xferEnd` closes the transaction.
- R7: Status bits [15:11] are error flags. `errPulse[k]` sets status bit 11+k. Writing a one to that bit with lane 3 enabled clears it, and with lane 3 disabled it stays unchanged. If a set and a clear fall in the same cycle, the flag stays set. The flags can be read at any time.
- R8: The base register reads 0 in bits [BAR_LSB-1:0], which marks a 32-bit non-prefetchable memory decode. With the default `BAR_LSB`=12, writing all ones reads back 32'hFFFFF000.
- R9: After reset, `claimed` and `rdValid` are 0, and the command bits, error flags, latency timer, interrupt line and base register all read 0.
- R10: `rdValid` is 1 exactly in the cycle after a claimed read data phase and carries that DWORD on `rdData`. It is 0 after write phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrValid | input | 1 | Address phase strobe |
| idsel | input | 1 | Device select for configuration cycles |
| cfgCmd | input | 1 | Command is a configuration read or write |
| cfgWrite | input | 1 | Direction of the transaction, 1 = write |
| adAddr | input | 11 | Address bits [10:0] of the address phase |
| dataValid | input | 1 | Data phase strobe |
| wrData | input | 32 | Write data of the data phase |
| byteEnN | input | 4 | Active-low byte lane enables |
| xferEnd | input | 1 | Ends the current transaction |
| errPulse | input | 5 | Error-detect pulses setting status bits 15:11 |
| claimed | output | 1 | The current transaction belongs to this function |
| rdValid | output | 1 | Read data is valid |
| rdData | output | 32 | Read data |

## Verification
The bound checker watches several rules on every cycle. An address phase that fails the select, command, alignment or function test never leads to a claim. `rdValid` never rises without a claimed data phase before it. An error pulse always leaves its flag set one cycle later. The command register never moves without a claimed write. Reads of index 0 and of indices 16 and above always return the identity word and zero. Lane masking, the base register size mask, the burst address walk, write-one-to-clear with the set-wins collision, and the survival of read-only fields after writes all need a particular stimulus order, so only the directed scenarios demonstrate them.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int ADDR_W   = 11;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int IDX_W    = 6;
  localparam int ERR_W    = 5;
  localparam int HDR_DW   = 16;

  // strobes handed from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [IDX_W-1:0] idx;
  } cfgStrobe_t;

  // header DWORD indices
  localparam logic [IDX_W-1:0] IDX_ID     = 6'd0;
  localparam logic [IDX_W-1:0] IDX_STSCMD = 6'd1;
  localparam logic [IDX_W-1:0] IDX_CLASS  = 6'd2;
  localparam logic [IDX_W-1:0] IDX_MISC   = 6'd3;
  localparam logic [IDX_W-1:0] IDX_BAR    = 6'd4;
  localparam logic [IDX_W-1:0] IDX_SUBSYS = 6'd11;
  localparam logic [IDX_W-1:0] IDX_INTR   = 6'd15;
endpackage

// File: rtl/pci_cfg_ctrl.sv
module pci_cfg_ctrl
  import pci_cfg_pkg::*;
#(
  parameter logic [2:0] FUNC_NUM = 3'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic              idsel,
  input  logic              cfgCmd,
  input  logic              cfgWrite,
  input  logic [ADDR_W-1:0] adAddr,
  input  logic              dataValid,
  input  logic              xferEnd,
  output cfgStrobe_t        strobe,
  output logic              claimed,
  output logic              isWrite,
  output logic [IDX_W-1:0]  curIdx
);
  logic addrHit;
  logic phaseAct;

  assign addrHit  = idsel && cfgCmd && (adAddr[1:0] == 2'b00) && (adAddr[10:8] == FUNC_NUM);
  assign phaseAct = claimed && dataValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      claimed <= 1'b0;
      isWrite <= 1'b0;
      curIdx  <= '0;
    end else if (addrValid) begin
      claimed <= addrHit;
      isWrite <= cfgWrite;
      curIdx  <= adAddr[7:2];
    end else if (xferEnd) begin
      claimed <= 1'b0;
    end else if (phaseAct) begin
      curIdx <= curIdx + 1'b1;
    end
  end

  always_comb begin
    strobe.wrEn = phaseAct && isWrite;
    strobe.rdEn = phaseAct && !isWrite;
    strobe.idx  = curIdx;
  end
endmodule

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID   = 16'h0C3D,
  parameter logic [7:0]  REV_ID      = 8'h05,
  parameter logic [23:0] CLASS_CODE  = 24'h048000,
  parameter logic [7:0]  HEADER_TYPE = 8'h80,
  parameter logic [15:0] SUBSYS_VID  = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID   = 16'h0001,
  parameter logic [15:0] CMD_WMASK   = 16'h0146,
  parameter logic [15:0] STATUS_RO   = 16'h0200,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GNT     = 8'h10,
  parameter logic [7:0]  MAX_LAT     = 8'h28,
  parameter int          BAR_LSB     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  byteEnN,
  input  logic [ERR_W-1:0]  errPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [15:0]       cmdReg,
  output logic [ERR_W-1:0]  statusErr
);
  localparam logic [DATA_W-1:0] BAR_MASK = ~((DATA_W'(1) << BAR_LSB) - DATA_W'(1));

  logic [DATA_W-1:0] laneMask;
  logic [7:0]        latTimer;
  logic [7:0]        intLine;
  logic [DATA_W-1:0] barReg;
  logic [ERR_W-1:0]  errClr;
  logic [15:0]       cmdMask;
  logic [DATA_W-1:0] barWMask;
  logic [DATA_W-1:0] rdMux;
  logic              hitStsCmd, hitMisc, hitBar, hitIntr;

  // one byte of mask per enabled lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneMask[8*g +: 8] = {8{~byteEnN[g]}};
  end

  assign hitStsCmd = strobe.wrEn && (strobe.idx == IDX_STSCMD);
  assign hitMisc   = strobe.wrEn && (strobe.idx == IDX_MISC);
  assign hitBar    = strobe.wrEn && (strobe.idx == IDX_BAR);
  assign hitIntr   = strobe.wrEn && (strobe.idx == IDX_INTR);

  assign cmdMask  = CMD_WMASK & laneMask[15:0];
  assign barWMask = BAR_MASK & laneMask;
  assign errClr   = (hitStsCmd && !byteEnN[3]) ? wrData[31:32-ERR_W] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= '0;
      statusErr <= '0;
      latTimer  <= '0;
      intLine   <= '0;
      barReg    <= '0;
    end else begin
      if (hitStsCmd) cmdReg <= (cmdReg & ~cmdMask) | (wrData[15:0] & cmdMask);
      statusErr <= (statusErr & ~errClr) | errPulse;
      if (hitMisc && !byteEnN[1]) latTimer <= wrData[15:8];
      if (hitIntr && !byteEnN[0]) intLine <= wrData[7:0];
      if (hitBar) barReg <= (barReg & ~barWMask) | (wrData & barWMask);
    end
  end

  always_comb begin
    unique case (strobe.idx)
      IDX_ID:     rdMux = {DEVICE_ID, VENDOR_ID};
      IDX_STSCMD: rdMux = {statusErr, STATUS_RO[15-ERR_W:0], cmdReg};
      IDX_CLASS:  rdMux = {CLASS_CODE, REV_ID};
      IDX_MISC:   rdMux = {8'h00, HEADER_TYPE, latTimer, 8'h00};
      IDX_BAR:    rdMux = barReg;
      IDX_SUBSYS: rdMux = {SUBSYS_ID, SUBSYS_VID};
      IDX_INTR:   rdMux = {MAX_LAT, MIN_GNT, INT_PIN, intLine};
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= rdMux;
    end
  end
endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pci_cfg_pkg::*;
#(
  parameter logic [2:0]  FUNC_NUM    = 3'd0,
  parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID   = 16'h0C3D,
  parameter logic [7:0]  REV_ID      = 8'h05,
  parameter logic [23:0] CLASS_CODE  = 24'h048000,
  parameter logic [7:0]  HEADER_TYPE = 8'h80,
  parameter logic [15:0] SUBSYS_VID  = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID   = 16'h0001,
  parameter logic [15:0] CMD_WMASK   = 16'h0146,
  parameter logic [15:0] STATUS_RO   = 16'h0200,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GNT     = 8'h10,
  parameter logic [7:0]  MAX_LAT     = 8'h28,
  parameter int          BAR_LSB     = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrValid,
  input  logic        idsel,
  input  logic        cfgCmd,
  input  logic        cfgWrite,
  input  logic [10:0] adAddr,
  input  logic        dataValid,
  input  logic [31:0] wrData,
  input  logic [3:0]  byteEnN,
  input  logic        xferEnd,
  input  logic [4:0]  errPulse,
  output logic        claimed,
  output logic        rdValid,
  output logic [31:0] rdData
);
  cfgStrobe_t       strobe;
  logic             isWrite;
  logic [IDX_W-1:0] curIdx;
  logic [15:0]      cmdReg;
  logic [ERR_W-1:0] statusErr;

  pci_cfg_ctrl #(.FUNC_NUM(FUNC_NUM)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .idsel(idsel),
    .cfgCmd(cfgCmd), .cfgWrite(cfgWrite), .adAddr(adAddr),
    .dataValid(dataValid), .xferEnd(xferEnd), .strobe(strobe),
    .claimed(claimed), .isWrite(isWrite), .curIdx(curIdx)
  );

  pci_cfg_regs #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
    .CLASS_CODE(CLASS_CODE), .HEADER_TYPE(HEADER_TYPE),
    .SUBSYS_VID(SUBSYS_VID), .SUBSYS_ID(SUBSYS_ID), .CMD_WMASK(CMD_WMASK),
    .STATUS_RO(STATUS_RO), .INT_PIN(INT_PIN), .MIN_GNT(MIN_GNT),
    .MAX_LAT(MAX_LAT), .BAR_LSB(BAR_LSB)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .byteEnN(byteEnN), .errPulse(errPulse), .rdData(rdData),
    .rdValid(rdValid), .cmdReg(cmdReg), .statusErr(statusErr)
  );
endmodule

// File: rtl/pci_cfg_header_chk.sv
module pci_cfg_header_chk #(
  parameter logic [2:0]  FUNC_NUM  = 3'd0,
  parameter logic [15:0] VENDOR_ID = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID = 16'h0C3D
) (
  input logic        clk,
  input logic        rstN,
  input logic        addrValid,
  input logic        idsel,
  input logic        cfgCmd,
  input logic [10:0] adAddr,
  input logic        dataValid,
  input logic [4:0]  errPulse,
  input logic        claimed,
  input logic        rdValid,
  input logic [31:0] rdData,
  input logic        isWrite,
  input logic [5:0]  curIdx,
  input logic [15:0] cmdReg,
  input logic [4:0]  statusErr
);
  // R1
  claim_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !(idsel && cfgCmd && adAddr[1:0] == 2'b00 && adAddr[10:8] == FUNC_NUM))
      |=> !claimed);

  // R10
  rd_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(dataValid && claimed && !isWrite));

  // R7
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse != 5'd0) |=> ((statusErr & $past(errPulse)) == $past(errPulse)));

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dataValid && claimed && isWrite) |=> $stable(cmdReg));

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && claimed && !isWrite && curIdx == 6'd0) |=> rdData == {DEVICE_ID, VENDOR_ID});

  // R5
  beyond_hdr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && claimed && !isWrite && curIdx >= 6'd16) |=> rdData == 32'd0);
endmodule

bind pci_cfg_header pci_cfg_header_chk #(
  .FUNC_NUM(FUNC_NUM), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
) u_chk (
  .clk(clk), .rstN(rstN), .addrValid(addrValid), .idsel(idsel),
  .cfgCmd(cfgCmd), .adAddr(adAddr), .dataValid(dataValid),
  .errPulse(errPulse), .claimed(claimed), .rdValid(rdValid),
  .rdData(rdData), .isWrite(isWrite), .curIdx(curIdx),
  .cmdReg(cmdReg), .statusErr(statusErr)
);

// File: tb/pci_cfg_header_bench.sv
`timescale 1ns/1ps
module pci_cfg_header_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0, idsel = 1'b0, cfgCmd = 1'b0, cfgWrite = 1'b0;
  logic [10:0] adAddr = '0;
  logic        dataValid = 1'b0;
  logic [31:0] wrData = '0;
  logic [3:0]  byteEnN = 4'hF;
  logic        xferEnd = 1'b0;
  logic [4:0]  errPulse = '0;
  logic        claimed, rdValid;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pci_cfg_header u_pci_cfg_header (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .idsel(idsel),
    .cfgCmd(cfgCmd), .cfgWrite(cfgWrite), .adAddr(adAddr),
    .dataValid(dataValid), .wrData(wrData), .byteEnN(byteEnN),
    .xferEnd(xferEnd), .errPulse(errPulse), .claimed(claimed),
    .rdValid(rdValid), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic startXfer(input logic sel, input logic cmd, input logic wr,
                           input logic [2:0] fn, input logic [5:0] idx, input logic [1:0] lo);
    @(negedge clk);
    addrValid = 1'b1; idsel = sel; cfgCmd = cmd; cfgWrite = wr;
    adAddr = {fn, idx, lo};
    @(negedge clk);
    addrValid = 1'b0; idsel = 1'b0; cfgCmd = 1'b0;
  endtask

  task automatic endXfer();
    xferEnd = 1'b1;
    @(negedge clk);
    xferEnd = 1'b0;
  endtask

  // one data phase; returns rdValid/rdData sampled the cycle after
  task automatic phase(input logic [31:0] d, input logic [3:0] be,
                       output logic rv, output logic [31:0] rd);
    dataValid = 1'b1; wrData = d; byteEnN = be;
    @(negedge clk);
    rv = rdValid; rd = rdData;
    dataValid = 1'b0; byteEnN = 4'hF; errPulse = '0;
  endtask

  task automatic cfgWr(input logic [5:0] idx, input logic [31:0] d, input logic [3:0] be);
    logic rv; logic [31:0] rd;
    startXfer(1'b1, 1'b1, 1'b1, 3'd0, idx, 2'b00);
    phase(d, be, rv, rd);
    check("R10 no rdValid after write", {31'd0, rv}, 32'd0);
    endXfer();
  endtask

  task automatic cfgRd(input logic [5:0] idx, output logic [31:0] rd);
    logic rv;
    startXfer(1'b1, 1'b1, 1'b0, 3'd0, idx, 2'b00);
    phase(32'd0, 4'h0, rv, rd);
    check("R10 rdValid after read", {31'd0, rv}, 32'd1);
    endXfer();
  endtask

  task automatic testReset();
    logic [31:0] rd;
    check("R9 claimed after reset", {31'd0, claimed}, 32'd0);
    check("R9 rdValid after reset", {31'd0, rdValid}, 32'd0);
    cfgRd(6'd1, rd);  check("R9 status/command reset", rd, 32'h02000000);
    cfgRd(6'd4, rd);  check("R9 base register reset", rd, 32'h0);
    cfgRd(6'd3, rd);  check("R9 latency timer reset", rd, 32'h00800000);
    cfgRd(6'd15, rd); check("R9 interrupt line reset", rd, 32'h28100100);
  endtask

  task automatic testClaim();
    logic rv; logic [31:0] rd;
    // idsel low
    startXfer(1'b0, 1'b1, 1'b1, 3'd0, 6'd1, 2'b00);
    check("R1 idsel low not claimed", {31'd0, claimed}, 32'd0);
    phase(32'hFFFFFFFF, 4'h0, rv, rd); endXfer();
    // misaligned low address bits
    startXfer(1'b1, 1'b1, 1'b1, 3'd0, 6'd1, 2'b01);
    check("R1 AD[1:0]!=00 not claimed", {31'd0, claimed}, 32'd0);
    phase(32'hFFFFFFFF, 4'h0, rv, rd); endXfer();
    // other function number
    startXfer(1'b1, 1'b1, 1'b1, 3'd1, 6'd1, 2'b00);
    check("R1 function 1 not claimed", {31'd0, claimed}, 32'd0);
    phase(32'hFFFFFFFF, 4'h0, rv, rd); endXfer();
    // not a configuration command
    startXfer(1'b1, 1'b0, 1'b0, 3'd0, 6'd0, 2'b00);
    check("R1 non-config not claimed", {31'd0, claimed}, 32'd0);
    phase(32'h0, 4'h0, rv, rd);
    check("R1 no read data when unclaimed", {31'd0, rv}, 32'd0);
    endXfer();
    startXfer(1'b1, 1'b1, 1'b0, 3'd0, 6'd1, 2'b00);
    check("R1 valid cycle claimed", {31'd0, claimed}, 32'd1);
    phase(32'h0, 4'h0, rv, rd);
    check("R1 command untouched by ignored writes", rd, 32'h02000000);
    endXfer();
  endtask

  task automatic testReadOnly();
    logic [31:0] rd;
    cfgRd(6'd0, rd);  check("R2 identity word", rd, 32'h0C3D1A2B);
    cfgRd(6'd2, rd);  check("R2 class/revision word", rd, 32'h04800005);
    cfgRd(6'd11, rd); check("R2 subsystem word", rd, 32'h00011A2B);
    cfgWr(6'd0, 32'hFFFFFFFF, 4'h0);
    cfgRd(6'd0, rd);  check("R4 identity after write", rd, 32'h0C3D1A2B);
    cfgWr(6'd2, 32'h0, 4'h0);
    cfgRd(6'd2, rd);  check("R4 class after write", rd, 32'h04800005);
    cfgWr(6'd3, 32'hFFFF00FF, 4'h0);
    cfgRd(6'd3, rd);  check("R4 header type, BIST, cache line fixed", rd, 32'h00800000);
  endtask

  task automatic testLanes();
    logic [31:0] rd;
    cfgWr(6'd1, 32'hFFFFFFFF, 4'b1110);
    cfgRd(6'd1, rd);  check("R3 command lane 0 only", rd, 32'h02000046);
    cfgWr(6'd1, 32'hFFFFFFFF, 4'b1101);
    cfgRd(6'd1, rd);  check("R4 command lane 1 masked", rd, 32'h02000146);
    cfgWr(6'd1, 32'h00000000, 4'b1101);
    cfgRd(6'd1, rd);  check("R3 command lane 1 cleared", rd, 32'h02000046);
    cfgWr(6'd3, 32'hAABBCCDD, 4'b1101);
    cfgRd(6'd3, rd);  check("R3 latency timer lane 1", rd, 32'h0080CC00);
    cfgWr(6'd3, 32'h11223344, 4'b1011);
    cfgRd(6'd3, rd);  check("R3 latency untouched by lane 2", rd, 32'h0080CC00);
    cfgWr(6'd15, 32'hFFFFFF5A, 4'b1110);
    cfgRd(6'd15, rd); check("R3 interrupt line lane 0", rd, 32'h2810015A);
  endtask

  task automatic testBar();
    logic [31:0] rd;
    cfgWr(6'd4, 32'hFFFFFFFF, 4'h0);
    cfgRd(6'd4, rd);  check("R8 size mask", rd, 32'hFFFFF000);
    cfgWr(6'd4, 32'h00000000, 4'b0111);
    cfgRd(6'd4, rd);  check("R8 lane 3 cleared only", rd, 32'h00FFF000);
  endtask

  task automatic testReserved();
    logic [31:0] rd;
    cfgWr(6'd6, 32'hFFFFFFFF, 4'h0);
    cfgRd(6'd6, rd);  check("R5 index 6 zero", rd, 32'h0);
    cfgWr(6'd12, 32'hFFFFFFFF, 4'h0);
    cfgRd(6'd12, rd); check("R5 expansion ROM zero", rd, 32'h0);
    cfgRd(6'd10, rd); check("R5 CardBus pointer zero", rd, 32'h0);
    cfgWr(6'd20, 32'hFFFFFFFF, 4'h0);
    cfgRd(6'd20, rd); check("R5 index 20 zero", rd, 32'h0);
  endtask

  task automatic testBurst();
    logic rv; logic [31:0] rd;
    startXfer(1'b1, 1'b1, 1'b1, 3'd0, 6'd3, 2'b00);
    phase(32'h00007700, 4'b1101, rv, rd);
    phase(32'h12345678, 4'h0, rv, rd);
    endXfer();
    startXfer(1'b1, 1'b1, 1'b0, 3'd0, 6'd0, 2'b00);
    phase(32'h0, 4'h0, rv, rd); check("R6 burst read dw0", rd, 32'h0C3D1A2B);
    phase(32'h0, 4'h0, rv, rd); check("R6 burst read dw1", rd, 32'h02000046);
    phase(32'h0, 4'h0, rv, rd); check("R6 burst read dw2", rd, 32'h04800005);
    phase(32'h0, 4'h0, rv, rd); check("R6 burst write landed on dw3", rd, 32'h00807700);
    phase(32'h0, 4'h0, rv, rd); check("R6 burst write landed on dw4", rd, 32'h12345000);
    endXfer();
  endtask

  task automatic testErrors();
    logic rv; logic [31:0] rd;
    @(negedge clk); errPulse = 5'b00101;
    @(negedge clk); errPulse = 5'b00000;
    cfgRd(6'd1, rd);  check("R7 error flags set", rd, 32'h2A000046);
    cfgWr(6'd1, 32'h08000000, 4'b1111);
    cfgRd(6'd1, rd);  check("R7 lane 3 off keeps flags", rd, 32'h2A000046);
    cfgWr(6'd1, 32'h08000000, 4'b0111);
    cfgRd(6'd1, rd);  check("R7 write one clears bit 11", rd, 32'h22000046);
    // set and clear of bit 13 in the same cycle
    startXfer(1'b1, 1'b1, 1'b1, 3'd0, 6'd1, 2'b00);
    errPulse = 5'b00100;
    phase(32'h20000000, 4'b0111, rv, rd);
    endXfer();
    cfgRd(6'd1, rd);  check("R7 set wins over clear", rd, 32'h22000046);
    cfgWr(6'd1, 32'hF8000000, 4'b0111);
    cfgRd(6'd1, rd);  check("R7 all flags cleared", rd, 32'h02000046);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClaim();
    testReadOnly();
    testLanes();
    testBar();
    testReserved();
    testBurst();
    testErrors();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule